// File: doc/BRIEF.md
# Reversible-Gate Three-Bit Magnitude Comparator

This block compares two unsigned operands (three bits wide by default) and raises exactly one of three flags: the first operand is greater, the operands are equal, or the first operand is smaller. It is combinational. Every logic function inside it comes from an instance of a small bijective gate module: a one-through 3x3 comparison gate, a 4x4 dual-copy gate, a 3x3 controlled-swap gate and a 2x2 controlled-NOT gate. No plain AND, OR or XOR operator is used outside those gate modules. Constant inputs (ancillas) are tied inside the block.

Each bit position feeds one comparison gate with a zero ancilla. That gate yields the bit-level match (XNOR) and the bit-level win (a AND NOT b) at once. A chain of merge stages then walks from the most significant bit downward. Two controlled-swap gates act as AND gates, and one controlled-NOT gate merges the two mutually exclusive "greater" terms. The smaller flag is not computed from the operands. It comes from the other two flags through one more comparison gate. Every gate output that drives neither a flag nor another gate is collected on an internal garbage bus, and the width of that bus is reported on a port.

Top module: `rev_mag_cmp`

## Requirements
- R1: `gt` is 1 exactly when, at the most significant bit position where `a` and `b` differ, `a` holds 1 and `b` holds 0; it is 0 when the operands are equal.
- R2: `eq` is 1 exactly when every bit of `a` matches the bit of `b` at the same position.
- R3: `lt` is 1 exactly when both `gt` and `eq` are 0.
- R4: For every operand pair, exactly one of `gt`, `eq`, `lt` is 1.
- R5: The comparison gate maps (x, y, z) to (x, NOT(x XOR y), (x AND NOT y) XOR z), and its 8 input patterns give 8 distinct outputs.
- R6: The dual-copy gate maps (w, x, y, z) to (w, w XOR x, y, y XOR z), and its 16 input patterns give 16 distinct outputs.
- R7: The controlled-swap gate maps (c, x, y) to (c, x when c=0 else y, y when c=0 else x), and its 8 input patterns give 8 distinct outputs.
- R8: The controlled-NOT gate maps (c, x) to (c, c XOR x), and its 4 input patterns give 4 distinct outputs.
- R9: `garbage_count` equals 5*WIDTH-2, which is 13 at the default width. An output counts as garbage when it drives neither a flag nor another gate.
- R10: With parameter COPY_VIA_DG set to 1, the fan-out of the equal flag uses a comparison gate instead of the dual-copy gate. The flags and the garbage count are the same as with the default value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| gt | output | 1 | High when a is greater than b |
| eq | output | 1 | High when a equals b |
| lt | output | 1 | High when a is less than b |
| garbage_count | output | GCW | Number of unused gate outputs in the netlist |

## Verification
The greater and equal functions share the merge chain, and both could wrongly assert for the same operand pair. The smaller flag is produced from those two, so a collision would also hide itself there. The bench applies all 64 operand pairs to both fan-out variants and compares each of the three flags against values computed from integer comparison. It also checks that the count of high flags is one. Pairs that differ only in the least significant bit give the longest run of equal upper bits, and they are the ones most likely to provoke a double assertion.

// File: rtl/rc_pkg.sv
package rc_pkg;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } rc_flags_t;

    // one spare pass-through per bit slice, four per merge stage, two at the fan-out
    function automatic int garbage_total(input int w);
        return w + 4 * (w - 1) + 2;
    endfunction

    function automatic int count_width(input int w);
        return $clog2(garbage_total(w) + 1);
    endfunction

endpackage

// File: rtl/rg_feynman.sv
module rg_feynman (
    input  logic a,
    input  logic b,
    output logic p,
    output logic q
);
    assign p = a;
    assign q = a ^ b;
endmodule

// File: rtl/rg_fredkin.sv
module rg_fredkin (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic p,
    output logic q,
    output logic r
);
    assign p = a;
    assign q = (~a & b) ^ (a & c);
    assign r = (~a & c) ^ (a & b);
endmodule

// File: rtl/rg_dg.sv
module rg_dg (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic p,
    output logic q,
    output logic r
);
    assign p = a;
    assign q = ~(a ^ b);
    assign r = (a & ~b) ^ c;
endmodule

// File: rtl/rg_bvf.sv
module rg_bvf (
    input  logic a,
    input  logic b,
    input  logic c,
    input  logic d,
    output logic p,
    output logic q,
    output logic r,
    output logic s
);
    assign p = a;
    assign q = a ^ b;
    assign r = c;
    assign s = c ^ d;
endmodule

// File: rtl/rc_merge_stage.sv
module rc_merge_stage (
    input  logic       gt_hi,
    input  logic       eq_hi,
    input  logic       gt_bit,
    input  logic       eq_bit,
    output logic       gt_lo,
    output logic       eq_lo,
    output logic [3:0] garb_o
);
    logic eq_pass;
    logic win;

    // AND of upper-equal and this bit's win, with upper-equal passed on
    rg_fredkin u_and_win (
        .a(eq_hi), .b(1'b0), .c(gt_bit),
        .p(eq_pass), .q(win), .r(garb_o[0])
    );

    // AND of upper-equal and this bit's match
    rg_fredkin u_and_eq (
        .a(eq_pass), .b(1'b0), .c(eq_bit),
        .p(garb_o[1]), .q(eq_lo), .r(garb_o[2])
    );

    // win and gt_hi never both high, so XOR acts as OR
    rg_feynman u_merge (
        .a(win), .b(gt_hi),
        .p(garb_o[3]), .q(gt_lo)
    );

    always_comb begin
        if (!$isunknown({gt_hi, eq_hi, gt_bit, eq_bit, gt_lo, eq_lo})) begin
            assert_gt_sticky_R1: assert (!gt_hi || gt_lo)
                else $error("upper win lost in merge stage");
            assert_eq_needs_all_R2: assert (!eq_lo || (eq_hi && eq_bit))
                else $error("equal raised without full match");
            assert_no_double_R4: assert (!(gt_lo && eq_lo))
                else $error("greater and equal both high");
        end
    end
endmodule

// File: rtl/rev_mag_cmp.sv
module rev_mag_cmp #(
    parameter int WIDTH       = 3,
    parameter bit COPY_VIA_DG = 1'b0,
    localparam int GCW        = rc_pkg::count_width(WIDTH)
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             gt,
    output logic             eq,
    output logic             lt,
    output logic [GCW-1:0]   garbage_count
);
    import rc_pkg::*;

    localparam int NG = garbage_total(WIDTH);

    logic [NG-1:0]    unused_garbage;
    logic [WIDTH-1:0] bit_eq;
    logic [WIDTH-1:0] bit_gt;
    logic [WIDTH-1:0] acc_gt;
    logic [WIDTH-1:0] acc_eq;
    rc_flags_t        flags;

    // per-bit comparison gate with a zero ancilla
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        rg_dg u_bit (
            .a(a[i]), .b(b[i]), .c(1'b0),
            .p(unused_garbage[i]), .q(bit_eq[i]), .r(bit_gt[i])
        );
    end

    assign acc_gt[WIDTH-1] = bit_gt[WIDTH-1];
    assign acc_eq[WIDTH-1] = bit_eq[WIDTH-1];

    // walk from the top bit downward
    for (genvar i = WIDTH - 2; i >= 0; i--) begin : g_chain
        rc_merge_stage u_stage (
            .gt_hi (acc_gt[i+1]),
            .eq_hi (acc_eq[i+1]),
            .gt_bit(bit_gt[i]),
            .eq_bit(bit_eq[i]),
            .gt_lo (acc_gt[i]),
            .eq_lo (acc_eq[i]),
            .garb_o(unused_garbage[WIDTH + 4*i +: 4])
        );
    end

    if (COPY_VIA_DG) begin : g_fan_dg
        logic eq_cp;
        rg_dg u_copy (
            .a(acc_eq[0]), .b(1'b1), .c(1'b0),
            .p(flags.eq), .q(eq_cp), .r(unused_garbage[NG-1])
        );
        rg_dg u_less (
            .a(acc_gt[0]), .b(eq_cp), .c(1'b0),
            .p(flags.gt), .q(flags.lt), .r(unused_garbage[NG-2])
        );
    end else begin : g_fan_bvf
        logic gt_cp;
        logic eq_cp;
        rg_bvf u_copy (
            .a(acc_gt[0]), .b(1'b0), .c(acc_eq[0]), .d(1'b0),
            .p(flags.gt), .q(gt_cp), .r(flags.eq), .s(eq_cp)
        );
        rg_dg u_less (
            .a(gt_cp), .b(eq_cp), .c(1'b0),
            .p(unused_garbage[NG-1]), .q(flags.lt), .r(unused_garbage[NG-2])
        );
    end

    assign gt            = flags.gt;
    assign eq            = flags.eq;
    assign lt            = flags.lt;
    assign garbage_count = GCW'($bits(unused_garbage));

    always_comb begin
        if (!$isunknown({a, b, flags, bit_gt, bit_eq})) begin
            assert_one_flag_R4: assert ($countones(flags) == 1)
                else $error("flag set not one-hot");
            assert_lt_from_rest_R3: assert (flags.lt == !(flags.gt || flags.eq))
                else $error("less flag disagrees with the others");
            assert_bit_excl_R1: assert ((bit_gt & bit_eq) == '0)
                else $error("bit both wins and matches");
            assert_eq_all_bits_R2: assert (!flags.eq || (&bit_eq))
                else $error("equal flag with a mismatching bit");
        end
    end
endmodule

// File: tb/tb_rev_mag_cmp.sv
module tb_rev_mag_cmp;
    localparam int W   = 3;
    localparam int GCW = rc_pkg::count_width(W);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int tests  = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0]   a, b;
    logic           gt, eq, lt, gt2, eq2, lt2;
    logic [GCW-1:0] gc, gc2;

    rev_mag_cmp #(.WIDTH(W), .COPY_VIA_DG(1'b0)) dut (
        .a(a), .b(b), .gt(gt), .eq(eq), .lt(lt), .garbage_count(gc)
    );
    rev_mag_cmp #(.WIDTH(W), .COPY_VIA_DG(1'b1)) dut_alt (
        .a(a), .b(b), .gt(gt2), .eq(eq2), .lt(lt2), .garbage_count(gc2)
    );

    logic [3:0] gi;
    logic [3:0] dg_o, fk_o, bv_o;
    logic [1:0] fy_o;
    rg_dg      u_dg (.a(gi[2]), .b(gi[1]), .c(gi[0]), .p(dg_o[2]), .q(dg_o[1]), .r(dg_o[0]));
    rg_fredkin u_fk (.a(gi[2]), .b(gi[1]), .c(gi[0]), .p(fk_o[2]), .q(fk_o[1]), .r(fk_o[0]));
    rg_bvf     u_bv (.a(gi[3]), .b(gi[2]), .c(gi[1]), .d(gi[0]),
                     .p(bv_o[3]), .q(bv_o[2]), .r(bv_o[1]), .s(bv_o[0]));
    rg_feynman u_fy (.a(gi[1]), .b(gi[0]), .p(fy_o[1]), .q(fy_o[0]));
    assign dg_o[3] = 1'b0;
    assign fk_o[3] = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset_state;
        a = '0; b = '0;
        @(negedge clk);
        check("R2 initial equal", {29'd0, gt, eq, lt}, 32'b010);
    endtask

    task automatic t_all_pairs;
        for (int x = 0; x < 8; x++) begin
            for (int y = 0; y < 8; y++) begin
                a = 3'(x); b = 3'(y);
                #5;
                check("R1 gt", {31'd0, gt}, {31'd0, x > y});
                check("R2 eq", {31'd0, eq}, {31'd0, x == y});
                check("R3 lt", {31'd0, lt}, {31'd0, !(gt || eq)});
                check("R3 lt value", {31'd0, lt}, {31'd0, x < y});
                check("R4 one-hot", $countones({gt, eq, lt}), 32'd1);
                check("R10 alt flags", {29'd0, gt2, eq2, lt2}, {29'd0, x > y, x == y, x < y});
            end
        end
    endtask

    task automatic t_lsb_only;
        // upper bits equal, only the lowest differs
        a = 3'b101; b = 3'b100; #5;
        check("R1 lsb win", {29'd0, gt, eq, lt}, 32'b100);
        a = 3'b110; b = 3'b111; #5;
        check("R3 lsb loss", {29'd0, gt, eq, lt}, 32'b001);
        a = 3'b011; b = 3'b100; #5;
        check("R1 msb decides", {29'd0, gt, eq, lt}, 32'b001);
    endtask

    task automatic t_dg;
        bit seen[8];
        for (int v = 0; v < 8; v++) seen[v] = 1'b0;
        for (int v = 0; v < 8; v++) begin
            gi = 4'(v); #2;
            check("R5 dg map", {29'd0, dg_o[2:0]},
                  {29'd0, gi[2], ~(gi[2] ^ gi[1]), (gi[2] & ~gi[1]) ^ gi[0]});
            check("R5 dg distinct", {31'd0, seen[dg_o[2:0]]}, 32'd0);
            seen[dg_o[2:0]] = 1'b1;
        end
    endtask

    task automatic t_fredkin;
        bit seen[8];
        for (int v = 0; v < 8; v++) seen[v] = 1'b0;
        for (int v = 0; v < 8; v++) begin
            gi = 4'(v); #2;
            check("R7 fredkin map", {29'd0, fk_o[2:0]},
                  gi[2] ? {29'd0, gi[2], gi[0], gi[1]} : {29'd0, gi[2], gi[1], gi[0]});
            check("R7 fredkin distinct", {31'd0, seen[fk_o[2:0]]}, 32'd0);
            seen[fk_o[2:0]] = 1'b1;
        end
    endtask

    task automatic t_bvf;
        bit seen[16];
        for (int v = 0; v < 16; v++) seen[v] = 1'b0;
        for (int v = 0; v < 16; v++) begin
            gi = 4'(v); #2;
            check("R6 bvf map", {28'd0, bv_o},
                  {28'd0, gi[3], gi[3] ^ gi[2], gi[1], gi[1] ^ gi[0]});
            check("R6 bvf distinct", {31'd0, seen[bv_o]}, 32'd0);
            seen[bv_o] = 1'b1;
        end
    endtask

    task automatic t_feynman;
        bit seen[4];
        for (int v = 0; v < 4; v++) seen[v] = 1'b0;
        for (int v = 0; v < 4; v++) begin
            gi = 4'(v); #2;
            check("R8 cnot map", {30'd0, fy_o}, {30'd0, gi[1], gi[1] ^ gi[0]});
            check("R8 cnot distinct", {31'd0, seen[fy_o]}, 32'd0);
            seen[fy_o] = 1'b1;
        end
    endtask

    task automatic t_garbage;
        #2;
        check("R9 garbage count", 32'(gc), 32'(5 * W - 2));
        check("R10 alt garbage count", 32'(gc2), 32'd13);
    endtask

    initial begin
        a = '0; b = '0; gi = '0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_all_pairs();
        t_lsb_only();
        t_dg();
        t_fredkin();
        t_bvf();
        t_feynman();
        t_garbage();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule